// File: doc/BRIEF.md
# Packed Lane Shifter with Rounding and Saturation

This combinational block shifts a 32-bit word that holds either four 8-bit lanes or two 16-bit lanes. The lane layout and the signedness of a lane both come from the register indices of the instruction. Indices 2..7 select signed bytes and 8..15 select unsigned bytes. Indices 16..23 select signed halfwords and 24..29 select unsigned halfwords. Every lane is shifted by the same amount. No bit crosses from one lane into another.

Three shift kinds are offered: arithmetic right, logical right and logical left. The amount comes either from the low bits of a register operand or from an immediate. A two-bit mode field picks the ordinary shift (00) or the modified shift (01). For right shifts the modified shift rounds. For left shifts it saturates. Combinations that cannot be decoded raise an illegal flag and force the result to zero.

Top module: `pk_shift`

## Requirements
- R1: The lane width follows the bank of `idx_a`: indices 2..15 give 8-bit lanes and 16..29 give 16-bit lanes. `idx_d` must be in the same width group. `idx_b` must be in the same group as well when `imm_sel`=0. Any index outside 2..29 counts as a mismatch, and a mismatch sets `illegal`.
- R2: `illegal` is 1 when `kind`=11, when `mode[1]`=1, or when R1 reports a mismatch. While `illegal`=1, `res` is all zero.
- R3: When `imm_sel`=1 the amount is `imm_amt`, otherwise it is `amt_reg`. Only bits [2:0] are used for 8-bit lanes and bits [3:0] for 16-bit lanes.
- R4: `kind`=00 with `mode`=00 performs an arithmetic right shift of each lane.
- R5: `kind`=01 with `mode`=00 performs a logical right shift of each lane.
- R6: `kind`=10 with `mode`=00 performs a left shift of each lane. Bits that leave the top of a lane are lost.
- R7: With `mode`=01 a right shift (kind 00 or 01) adds the last bit shifted out to the truncated lane result.
- R8: With `mode`=01, `kind`=10 on signed lanes (banks 2..7 or 16..23, judged by `idx_a`), the lane saturates to the signed maximum or minimum whenever the shifted value does not fit in the lane.
- R9: With `mode`=01, `kind`=10 on unsigned lanes (banks 8..15 or 24..29), the lane becomes all ones whenever any bit shifted out is 1.
- R10: An effective amount of 0 returns `opa` unchanged in every legal kind and mode.
- R11: Each lane's result depends only on that lane's input bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | Packed operand |
| amt_reg | input | 4 | Low bits of the shift-amount register |
| imm_amt | input | 4 | Immediate shift amount |
| imm_sel | input | 1 | 1 selects the immediate amount |
| kind | input | 2 | 00 arith right, 01 logical right, 10 left, 11 reserved |
| mode | input | 2 | 00 plain, 01 round (right) or saturate (left) |
| idx_d | input | 5 | Destination register index |
| idx_a | input | 5 | Source register index, sets lane type |
| idx_b | input | 5 | Amount register index (checked when imm_sel=0) |
| res | output | 32 | Shifted word |
| illegal | output | 1 | Undecodable combination |

## Verification
The hardest cases to reach are the saturation edges. These include a signed lane whose shifted value exactly fills the lane versus one that spills by a single bit, a rounding bit that carries into a lane value, and an immediate above 7 that must wrap on byte lanes. Random operands seldom land on these edges, so the stimulus mixes directed words (lane extremes 0x7F, 0x80, 0x3FFF, 0xC000, all ones) with random words. It also biases the index draws toward legal banks, so that most random draws decode.

// File: rtl/pk_shift.sv
module pk_shift #(
  parameter int WORD = 32,
  parameter int IDXW = 5,
  parameter int AMTW = 4
) (
  input  logic [WORD-1:0] opa,
  input  logic [AMTW-1:0] amt_reg,
  input  logic [AMTW-1:0] imm_amt,
  input  logic            imm_sel,
  input  logic [1:0]      kind,
  input  logic [1:0]      mode,
  input  logic [IDXW-1:0] idx_d,
  input  logic [IDXW-1:0] idx_a,
  input  logic [IDXW-1:0] idx_b,
  output logic [WORD-1:0] res,
  output logic            illegal
);

  function automatic logic [1:0] grp(input logic [IDXW-1:0] i);
    if (i >= 2 && i <= 15) return 2'd1;
    if (i >= 16 && i <= 29) return 2'd2;
    return 2'd0;
  endfunction

  logic [1:0] ga, gd, gb;
  logic       half, sgn, mis;
  logic [AMTW-1:0] amt;

  assign ga   = grp(idx_a);
  assign gd   = grp(idx_d);
  assign gb   = grp(idx_b);
  assign half = (ga == 2'd2);
  assign sgn  = (idx_a < 8) || (idx_a >= 16 && idx_a < 24);
  assign mis  = (ga == 2'd0) || (gd != ga) || (!imm_sel && gb != ga);
  assign amt  = imm_sel ? imm_amt : amt_reg;
  assign illegal = (kind == 2'b11) || mode[1] || mis;

  logic [WORD-1:0] wres [2];

  for (genvar gw = 0; gw < 2; gw++) begin : g_w
    localparam int LW = 8 << gw;
    localparam int SW = $clog2(LW);
    localparam int NL = WORD / LW;
    logic [SW-1:0] s;
    assign s = amt[SW-1:0];
    for (genvar l = 0; l < NL; l++) begin : g_l
      logic [LW-1:0]   x, sra, srl, sll, rgt, lft, smax, smin;
      logic [2*LW-1:0] ws, wu;
      logic            rbit, ovs, ovu;
      assign x    = opa[l*LW +: LW];
      assign sra  = LW'($signed(x) >>> s);
      assign srl  = x >> s;
      assign sll  = x << s;
      assign rbit = (s != '0) && x[s - 1'b1];
      assign rgt  = (kind == 2'b00 ? sra : srl) +
                    ((mode == 2'b01) ? {{(LW-1){1'b0}}, rbit} : '0);
      assign ws   = {{LW{x[LW-1]}}, x} << s;
      assign wu   = {{LW{1'b0}}, x} << s;
      assign ovs  = ws[2*LW-1:LW-1] != {(LW+1){ws[LW-1]}};
      assign ovu  = |wu[2*LW-1:LW];
      assign smax = {1'b0, {(LW-1){1'b1}}};
      assign smin = {1'b1, {(LW-1){1'b0}}};
      always_comb begin
        lft = sll;
        if (mode == 2'b01) begin
          if (sgn && ovs)       lft = x[LW-1] ? smin : smax;
          else if (!sgn && ovu) lft = '1;
        end
      end
      assign wres[gw][l*LW +: LW] = (kind == 2'b10) ? lft : rgt;
    end
  end

  assign res = illegal ? '0 : (half ? wres[1] : wres[0]);

endmodule

// File: rtl/pk_shift_chk.sv
module pk_shift_chk (
  input logic [31:0] opa,
  input logic [3:0]  amt_reg,
  input logic [3:0]  imm_amt,
  input logic        imm_sel,
  input logic [1:0]  kind,
  input logic [1:0]  mode,
  input logic [4:0]  idx_a,
  input logic [31:0] res,
  input logic        illegal
);
  logic [3:0] eff;
  always_comb begin
    eff = imm_sel ? imm_amt : amt_reg;
    if (idx_a < 16) eff[3] = 1'b0;
    AST_ILLEGAL_ZERO: assert (!illegal || res == 32'd0);                          // R2
    AST_RESERVED_KIND: assert (kind != 2'b11 || illegal);                         // R2
    AST_ZERO_AMT_IDENT: assert (illegal || eff != 4'd0 || res == opa);            // R10
    AST_SLL_LOW_CLEAR: assert (illegal || kind != 2'b10 || mode != 2'b00 ||
                               eff == 4'd0 || res[0] == 1'b0);                    // R6
    AST_SRL_HALF_TOP: assert (illegal || kind != 2'b01 || mode != 2'b00 ||
                              idx_a < 16 || eff == 4'd0 ||
                              (res[31] == 1'b0 && res[15] == 1'b0));              // R5
  end
endmodule

bind pk_shift pk_shift_chk u_chk (
  .opa(opa), .amt_reg(amt_reg), .imm_amt(imm_amt), .imm_sel(imm_sel),
  .kind(kind), .mode(mode), .idx_a(idx_a), .res(res), .illegal(illegal)
);

// File: tb/pk_shift_bench.sv
module pk_shift_bench;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [31:0] opa;
  logic [3:0]  amt_reg, imm_amt;
  logic        imm_sel;
  logic [1:0]  kind, mode;
  logic [4:0]  idx_d, idx_a, idx_b;
  logic [31:0] res;
  logic        illegal;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R2";

  pk_shift u_pk_shift (.*);

  function automatic int grp(input int i);
    if (i >= 2 && i <= 15) return 1;
    if (i >= 16 && i <= 29) return 2;
    return 0;
  endfunction

  function automatic bit ref_ill();
    int g = grp(idx_a);
    return kind == 3 || mode[1] || g == 0 || grp(idx_d) != g ||
           (!imm_sel && grp(idx_b) != g);
  endfunction

  function automatic logic [31:0] ref_res();
    int lw, n, s, mask, x, xs, v, mx, mn;
    bit sg;
    logic [31:0] r = 0;
    if (ref_ill()) return 0;
    lw = (grp(idx_a) == 2) ? 16 : 8;
    n = 32 / lw;
    mask = (1 << lw) - 1;
    s = (imm_sel ? imm_amt : amt_reg) % lw;
    sg = idx_a < 8 || (idx_a >= 16 && idx_a < 24);
    mx = (1 << (lw - 1)) - 1;
    mn = -(1 << (lw - 1));
    for (int l = 0; l < n; l++) begin
      x = (opa >> (l * lw)) & mask;
      xs = (x > mx) ? x - (1 << lw) : x;
      if (kind == 0) begin
        v = xs >>> s;
        if (mode == 1 && s > 0) v = v + ((xs >>> (s - 1)) & 1);
      end else if (kind == 1) begin
        v = x >> s;
        if (mode == 1 && s > 0) v = v + ((x >> (s - 1)) & 1);
      end else begin
        if (mode == 1 && sg) begin
          v = xs * (1 << s);
          if (v > mx) v = mx;
          else if (v < mn) v = mn;
        end else begin
          v = x << s;
          if (mode == 1 && v > mask) v = mask;
        end
      end
      r = r | ((32'(v) & 32'(mask)) << (l * lw));
    end
    return r;
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    logic [31:0] er;
    bit ei;
    er = ref_res();
    ei = ref_ill();
    checks++;
    if (res !== er || illegal !== ei) begin
      fails++;
      $display("FAIL %s res=%h ill=%b expected res=%h ill=%b", tag, res, illegal, er, ei);
    end
  end

  task automatic drive(input string t, input logic [31:0] a, input logic [3:0] ar,
                       input logic [3:0] im, input logic is, input logic [1:0] k,
                       input logic [1:0] m, input logic [4:0] d, input logic [4:0] sa,
                       input logic [4:0] sb);
    @(posedge clk);
    tag = t; opa = a; amt_reg = ar; imm_amt = im; imm_sel = is;
    kind = k; mode = m; idx_d = d; idx_a = sa; idx_b = sb;
  endtask

  function automatic logic [4:0] pick_idx(input int g);
    case (g)
      0: return 5'($urandom_range(2, 7));
      1: return 5'($urandom_range(8, 15));
      2: return 5'($urandom_range(16, 23));
      default: return 5'($urandom_range(24, 29));
    endcase
  endfunction

  initial begin
    opa = 0; amt_reg = 0; imm_amt = 0; imm_sel = 0; kind = 0; mode = 0;
    idx_d = 0; idx_a = 0; idx_b = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    drive("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    drive("R4", 32'h80F0_7F01, 4'd3, 0, 0, 2'b00, 2'b00, 5'd3, 5'd4, 5'd5);
    drive("R5", 32'h80F0_7F01, 4'd3, 0, 0, 2'b01, 2'b00, 5'd9, 5'd10, 5'd11);
    drive("R6", 32'h8001_C000, 4'd5, 0, 0, 2'b10, 2'b00, 5'd17, 5'd18, 5'd19);
    drive("R7", 32'h00FF_0003, 4'd1, 0, 0, 2'b00, 2'b01, 5'd16, 5'd17, 5'd18);
    drive("R7", 32'hFFFF_7FFF, 4'd1, 0, 0, 2'b01, 2'b01, 5'd24, 5'd25, 5'd26);
    drive("R8", 32'h3FFF_4000, 4'd1, 0, 0, 2'b10, 2'b01, 5'd20, 5'd21, 5'd22);
    drive("R8", 32'hC000_BFFF, 4'd1, 0, 0, 2'b10, 2'b01, 5'd20, 5'd21, 5'd22);
    drive("R8", 32'h3F40_C07F, 4'd1, 0, 0, 2'b10, 2'b01, 5'd2, 5'd3, 5'd4);
    drive("R9", 32'h7F80_0140, 4'd1, 0, 0, 2'b10, 2'b01, 5'd12, 5'd13, 5'd14);
    drive("R3", 32'h1234_ABCD, 4'd0, 4'd12, 1, 2'b01, 2'b00, 5'd8, 5'd9, 5'd0);
    drive("R3", 32'h1234_ABCD, 4'd0, 4'd12, 1, 2'b01, 2'b00, 5'd24, 5'd25, 5'd0);
    drive("R10", 32'hDEAD_BEEF, 4'd8, 0, 0, 2'b10, 2'b01, 5'd6, 5'd7, 5'd2);
    drive("R1", 32'hDEAD_BEEF, 4'd1, 0, 0, 2'b00, 2'b00, 5'd16, 5'd7, 5'd2);
    drive("R1", 32'hDEAD_BEEF, 4'd1, 0, 0, 2'b00, 2'b00, 5'd2, 5'd7, 5'd30);
    drive("R1", 32'hDEAD_BEEF, 4'd1, 0, 1, 2'b00, 2'b00, 5'd2, 5'd7, 5'd30);
    drive("R2", 32'hDEAD_BEEF, 4'd1, 0, 0, 2'b11, 2'b00, 5'd2, 5'd3, 5'd4);
    drive("R2", 32'hDEAD_BEEF, 4'd1, 0, 0, 2'b00, 2'b10, 5'd2, 5'd3, 5'd4);
    drive("R11", 32'h0000_FF00, 4'd4, 0, 0, 2'b10, 2'b00, 5'd2, 5'd3, 5'd4);
    drive("R11", 32'h0100_0000, 4'd1, 0, 0, 2'b01, 2'b01, 5'd8, 5'd9, 5'd10);
    for (int i = 0; i < 3000; i++) begin
      int g;
      logic [31:0] a;
      logic [4:0] d, sa, sb;
      logic [1:0] k, m;
      g = $urandom_range(0, 3);
      sa = pick_idx(g);
      d = pick_idx(($urandom_range(0, 9) == 0) ? $urandom_range(0, 3) : g);
      sb = pick_idx(g);
      if ($urandom_range(0, 19) == 0) sb = 5'($urandom_range(0, 31));
      k = 2'($urandom_range(0, 2));
      if ($urandom_range(0, 29) == 0) k = 2'b11;
      m = 2'($urandom_range(0, 1));
      if ($urandom_range(0, 29) == 0) m = 2'b10;
      case ($urandom_range(0, 3))
        0: a = 32'h7F80_3FFF;
        1: a = 32'hC000_FF01;
        default: a = $urandom;
      endcase
      drive(k == 2 && m == 1 ? "R8" : (m == 1 ? "R7" : "R11"), a,
            4'($urandom), 4'($urandom), 1'($urandom), k, m, d, sa, sb);
    end
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #5_000_000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule